// File: doc/BRIEF.md
# Non-Restoring Division Step Sequencer

This block divides a positive dividend held in a wide accumulator by a positive divisor held in the upper half of a product register. It uses the non-restoring method: a single initial subtraction, then a chosen number of conditional add/subtract steps, then an optional correction that turns the working remainder into the true remainder. The quotient is built up in the accumulator itself, so quotient and remainder come back in the same register that held the dividend. The quotient is in the low word and the remainder is in the high word.

A caller presents the accumulator and product-register values, selects the word mode (24-bit or 16-bit), the number of quotient bits and whether the remainder is restored, and pulses `start`. Fewer steps give a quotient with fewer bits. The operands are checked when the unit accepts them. If they cannot give a representable quotient, the unit reports an error at once and runs no steps.

Top module: `nrdiv_top`

## Requirements
- R1: After reset, `accOut` is zero and `busy`, `done` and `err` are low.
- R2: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance up to and including the `done` cycle. A `start` pulse while `busy` is high changes neither the result nor the timing. While idle, `accOut` holds its value.
- R3: Call X = `accIn[47:0]`, Dv = `divisorIn[47:24]`, and let N be the effective step count. With restore enabled, the finished accumulator holds Xs mod Dv in bits 47:24, with bits 51:48 zero. Its low N bits hold floor(Xs / Dv), where Xs = X >> (24 − N).
- R4: With restore disabled and quotient bit 0 equal to 0, the upper field (bits 51:24, two's complement) holds (Xs mod Dv) − Dv. When quotient bit 0 is 1, that field holds Xs mod Dv.
- R5: With N below 24, accumulator bits 23:N hold the unconsumed dividend bits X[23−N:0].
- R6: A `stepCount` of 0 selects 24 steps in 24-bit mode and 16 steps in 16-bit mode. A value above 24 is clamped to 24.
- R7: In 16-bit mode (`mode16`=1), the dividend is a 32-bit value at `accIn[39:8]`, sign-extended through bit 51. The divisor is 16 bits at `divisorIn[39:24]`, sign-extended through bit 47. A full run leaves the 16-bit quotient in bits 15:0.
- R8: `done` is high for exactly one cycle. That cycle starts N+1 clock edges after the accepting edge, or N+2 edges with restore enabled.
- R9: `err` is raised at acceptance in any of these cases: the accumulator bits from 47 up (24-bit mode) or from 39 up (16-bit mode) are not all zero; the divisor bits in the same ranges of `divisorIn` are not all zero; `divisorIn[23:0]` is nonzero; or X ≥ `divisorIn`. In that case `done` and `err` are high in the cycle right after acceptance, and `accOut` equals the loaded `accIn`.
- R10: `err` keeps its value until the next accepted `start`. It is cleared by an accepted `start` whose operands are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| mode16 | input | 1 | 1 selects 16-bit operands, 0 selects 24-bit |
| stepCount | input | 5 | Quotient bits to produce (0 = full for the mode) |
| restoreEn | input | 1 | Run the final remainder correction |
| accIn | input | 52 | Dividend in accumulator layout |
| divisorIn | input | 48 | Product register holding the divisor in its upper half |
| accOut | output | 52 | Working and final accumulator |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operands rejected at the last accepted start |

## Verification
The bench builds the block with its default parameters: a 24-bit word, a 16-bit narrow word and a 4-bit extension. At those values both full-precision paths can be reached, 48/24 in 24-bit mode and 32/16 in 16-bit mode. Short runs of 1 and 8 steps can be reached as well, and so can the clamp for step counts from 25 to 31. Every error condition is reachable with small operand changes. Expected accumulators come from an integer model of quotient, remainder and the unrestored remainder, so restored and unrestored endings are both compared bit for bit.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_STEP,
    ST_RESTORE,
    ST_DONE
  } divState_t;

  typedef struct packed {
    logic load;
    logic doInit;
    logic doStep;
    logic doRestore;
  } divStrobe_t;

endpackage

// File: rtl/nrdiv_datapath.sv
module nrdiv_datapath
  import nrdiv_pkg::*;
#(
  parameter int HALF_W   = 24,
  parameter int NARROW_W = 16,
  parameter int EXT_W    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  divStrobe_t              strobe,
  input  logic                    mode16,
  input  logic [2*HALF_W+EXT_W-1:0] accIn,
  input  logic [2*HALF_W-1:0]     divisorIn,
  output logic [2*HALF_W+EXT_W-1:0] accOut,
  output logic                    operandErr
);

  localparam int ACC_W     = 2*HALF_W + EXT_W;
  localparam int P_W       = 2*HALF_W;
  localparam int WIDE_LO   = P_W - 1;
  localparam int NARROW_LO = HALF_W + NARROW_W - 1;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] divQ;
  logic [ACC_W-1:0] shifted;
  logic [ACC_W-1:0] stepSum;
  logic [ACC_W-1:0] stepNext;
  logic [ACC_W-1:0] restoreNext;
  logic             accHigh;
  logic             divHigh;
  logic             divLowNz;
  logic             notSmaller;

  // Operand screening on the values presented at start
  always_comb begin
    if (mode16) begin
      accHigh = accIn[ACC_W-1:NARROW_LO] != '0;
      divHigh = divisorIn[P_W-1:NARROW_LO] != '0;
    end else begin
      accHigh = accIn[ACC_W-1:WIDE_LO] != '0;
      divHigh = divisorIn[P_W-1:WIDE_LO] != '0;
    end
    divLowNz   = divisorIn[HALF_W-1:0] != '0;
    notSmaller = accIn[P_W-1:0] >= divisorIn;
    operandErr = accHigh | divHigh | divLowNz | notSmaller;
  end

  // One elementary step: shift, add or subtract by previous sign, insert bit
  always_comb begin
    shifted     = {accQ[ACC_W-2:0], 1'b0};
    stepSum     = accQ[ACC_W-1] ? (shifted + divQ) : (shifted - divQ);
    stepNext    = {stepSum[ACC_W-1:1], ~stepSum[ACC_W-1]};
    restoreNext = accQ[ACC_W-1] ? (accQ + divQ) : accQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      divQ <= '0;
    end else if (strobe.load) begin
      accQ <= accIn;
      divQ <= {{EXT_W{divisorIn[P_W-1]}}, divisorIn};
    end else if (strobe.doInit) begin
      accQ <= accQ - divQ;
    end else if (strobe.doStep) begin
      accQ <= stepNext;
    end else if (strobe.doRestore) begin
      accQ <= restoreNext;
    end
  end

  assign accOut = accQ;

endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int HALF_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       mode16,
  input  logic [$clog2(HALF_W+1)-1:0] stepCount,
  input  logic                       restoreEn,
  input  logic                       operandErr,
  output divStrobe_t                 strobe,
  output logic                       busy,
  output logic                       done,
  output logic                       err
);

  localparam int CNT_W = $clog2(HALF_W+1);
  localparam logic [CNT_W-1:0] FULL_WIDE   = CNT_W'(HALF_W);
  localparam logic [CNT_W-1:0] FULL_NARROW = CNT_W'(NARROW_W);

  divState_t        stateQ, stateNext;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] effSteps;
  logic             restoreQ;
  logic             errQ;
  logic             accept;

  always_comb begin
    if (stepCount == '0)
      effSteps = mode16 ? FULL_NARROW : FULL_WIDE;
    else if (stepCount > FULL_WIDE)
      effSteps = FULL_WIDE;
    else
      effSteps = stepCount;
  end

  assign accept = start && (stateQ == ST_IDLE);

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = operandErr ? ST_DONE : ST_INIT;
        end
      end
      ST_INIT: begin
        strobe.doInit = 1'b1;
        stateNext     = ST_STEP;
      end
      ST_STEP: begin
        strobe.doStep = 1'b1;
        if (cntQ == CNT_W'(1))
          stateNext = restoreQ ? ST_RESTORE : ST_DONE;
      end
      ST_RESTORE: begin
        strobe.doRestore = 1'b1;
        stateNext        = ST_DONE;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      restoreQ <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (accept) begin
        cntQ     <= effSteps;
        restoreQ <= restoreEn;
        errQ     <= operandErr;
      end else if (strobe.doStep) begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  assign busy = stateQ != ST_IDLE;
  assign done = stateQ == ST_DONE;
  assign err  = errQ;

endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
  import nrdiv_pkg::*;
#(
  parameter int HALF_W   = 24,
  parameter int NARROW_W = 16,
  parameter int EXT_W    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        mode16,
  input  logic [$clog2(HALF_W+1)-1:0] stepCount,
  input  logic                        restoreEn,
  input  logic [2*HALF_W+EXT_W-1:0]   accIn,
  input  logic [2*HALF_W-1:0]         divisorIn,
  output logic [2*HALF_W+EXT_W-1:0]   accOut,
  output logic                        busy,
  output logic                        done,
  output logic                        err
);

  divStrobe_t strobe;
  logic       operandErr;

  nrdiv_ctrl #(
    .HALF_W  (HALF_W),
    .NARROW_W(NARROW_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .mode16    (mode16),
    .stepCount (stepCount),
    .restoreEn (restoreEn),
    .operandErr(operandErr),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  nrdiv_datapath #(
    .HALF_W  (HALF_W),
    .NARROW_W(NARROW_W),
    .EXT_W   (EXT_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mode16    (mode16),
    .accIn     (accIn),
    .divisorIn (divisorIn),
    .accOut    (accOut),
    .operandErr(operandErr)
  );

endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
  parameter int ACC_W = 52
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [ACC_W-1:0] accOut
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R2

  AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(accOut)); // R2

  AST_ERR_FAST_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (err == done)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(start && !busy) |=> $stable(err)); // R10

endmodule

bind nrdiv_top nrdiv_checker #(.ACC_W(2*HALF_W+EXT_W)) i_nrdiv_checker (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .err   (err),
  .accOut(accOut)
);

// File: tb/test_nrdiv_top.sv
module test_nrdiv_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        mode16 = 1'b0;
  logic [4:0]  stepCount = '0;
  logic        restoreEn = 1'b0;
  logic [51:0] accIn = '0;
  logic [47:0] divisorIn = '0;
  logic [51:0] accOut;
  logic        busy, done, err;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrdiv_top i_nrdiv_top (
    .clk(clk), .rstN(rstN), .start(start), .mode16(mode16),
    .stepCount(stepCount), .restoreEn(restoreEn), .accIn(accIn),
    .divisorIn(divisorIn), .accOut(accOut), .busy(busy), .done(done), .err(err)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Integer model of the accumulator after n steps
  function automatic logic [51:0] model(input logic [47:0] x, input logic [23:0] dv, input int n, input bit rest);
    logic [63:0] xs, q, r, lowv, dv64;
    logic signed [63:0] u, full;
    dv64 = {40'b0, dv};
    xs   = {16'b0, x} >> (24 - n);
    q    = xs / dv64;
    r    = xs - q * dv64;
    u    = (rest || q[0]) ? $signed(r) : $signed(r) - $signed(dv64);
    lowv = (({40'b0, x[23:0]} << n) & 64'hFF_FFFF) | q;
    full = (u <<< 24) + $signed(lowv);
    return full[51:0];
  endfunction

  task automatic runDiv(input string req, input logic [51:0] a, input logic [47:0] p,
                        input bit m16, input logic [4:0] sc, input bit rs,
                        input logic [51:0] expAcc, input bit expErr, input int expLat, input bit poke);
    int lat = 0;
    bit busyOk = 1'b1;
    @(negedge clk);
    accIn = a; divisorIn = p; mode16 = m16; stepCount = sc; restoreEn = rs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 60) begin
      if (!busy) busyOk = 1'b0;
      if (poke && lat == 2) begin
        start = 1'b1; accIn = ~a; divisorIn = 48'h00_0001_000000; stepCount = 5'd1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(req, "accOut", {12'b0, accOut}, {12'b0, expAcc});
    check("R9", "err", {63'b0, err}, {63'b0, expErr});
    check("R8", "latency", 64'(lat), 64'(expLat));
    check("R2", "busy during run", {63'b0, busyOk & busy}, 64'd1);
    @(negedge clk);
    check("R8", "done single pulse", {62'b0, done, busy}, 64'd0);
    check("R2", "accOut held idle", {12'b0, accOut}, {12'b0, expAcc});
  endtask

  task automatic testReset;
    check("R1", "reset outputs", {accOut, busy, done, err, 9'b0}, 64'd0);
  endtask

  task automatic testFull24;
    logic [47:0] x = 48'h5123_4567_89AB;
    logic [23:0] dv = 24'h7A_1234;
    runDiv("R3", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd0, 1'b1, model(x, dv, 24, 1'b1), 1'b0, 26, 1'b0);
    x = 48'h0000_0300_0001; dv = 24'h00_0007;
    runDiv("R3", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd24, 1'b1, model(x, dv, 24, 1'b1), 1'b0, 26, 1'b0);
  endtask

  task automatic testNoRestore;
    logic [47:0] x = 48'h5123_4567_89AB;
    logic [23:0] dv = 24'h7A_1234;
    runDiv("R4", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd0, 1'b0, model(x, dv, 24, 1'b0), 1'b0, 25, 1'b0);
    x = 48'h0000_0000_0006; dv = 24'h00_0004;
    // quotient 1 remainder 2 after 24 steps: odd quotient path
    runDiv("R4", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd0, 1'b0, model(x, dv, 24, 1'b0), 1'b0, 25, 1'b0);
    x = 48'h0000_0000_0008;
    // quotient 2: even quotient leaves remainder minus divisor
    runDiv("R4", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd0, 1'b0, model(x, dv, 24, 1'b0), 1'b0, 25, 1'b0);
  endtask

  task automatic testShort;
    logic [47:0] x = 48'h2B3C_4D5E_6F70;
    logic [23:0] dv = 24'h3F_0101;
    runDiv("R5", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd8, 1'b1, model(x, dv, 8, 1'b1), 1'b0, 10, 1'b0);
    runDiv("R5", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd1, 1'b0, model(x, dv, 1, 1'b0), 1'b0, 2, 1'b0);
  endtask

  task automatic testClamp;
    logic [47:0] x = 48'h1111_2222_3333;
    logic [23:0] dv = 24'h55_AA55;
    runDiv("R6", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd31, 1'b1, model(x, dv, 24, 1'b1), 1'b0, 26, 1'b0);
  endtask

  task automatic testMode16;
    logic [47:0] x = {8'h00, 32'h1234_5678, 8'h00};
    logic [23:0] dv = {8'h00, 16'h4321};
    logic [51:0] e = model(x, dv, 16, 1'b1);
    runDiv("R7", {4'b0, x}, {dv, 24'h0}, 1'b1, 5'd0, 1'b1, e, 1'b0, 18, 1'b0);
    check("R7", "16-bit quotient", {48'b0, accOut[15:0]}, 64'(32'h1234_5678 / 32'h4321));
  endtask

  task automatic testErrors;
    logic [51:0] a;
    a = {4'b0, 24'h7A_1234, 24'h0};
    runDiv("R9", a, {24'h7A_1234, 24'h0}, 1'b0, 5'd0, 1'b1, a, 1'b1, 0, 1'b0);
    a = {4'b0100, 48'h0000_0100_0000};
    runDiv("R9", a, {24'h40_0000, 24'h0}, 1'b0, 5'd0, 1'b1, a, 1'b1, 0, 1'b0);
    a = {4'b0, 48'h0000_0100_0000};
    runDiv("R9", a, {24'h40_0000, 24'h00_0010}, 1'b0, 5'd0, 1'b1, a, 1'b1, 0, 1'b0);
    runDiv("R9", a, {24'h01_4321, 24'h0}, 1'b1, 5'd0, 1'b1, a, 1'b1, 0, 1'b0);
    @(negedge clk); @(negedge clk);
    check("R10", "err held while idle", {63'b0, err}, 64'd1);
  endtask

  task automatic testBusyIgnore;
    logic [47:0] x = 48'h0ABC_DEF0_1234;
    logic [23:0] dv = 24'h1F_FFFF;
    runDiv("R2", {4'b0, x}, {dv, 24'h0}, 1'b0, 5'd12, 1'b1, model(x, dv, 12, 1'b1), 1'b0, 14, 1'b1);
    check("R10", "err cleared by valid start", {63'b0, err}, 64'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFull24();
    testNoRestore();
    testShort();
    testClamp();
    testMode16();
    testErrors();
    testBusyIgnore();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule